// File: doc/BRIEF.md
# Global-History Hashed Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a table of saturating counters and one register holding the outcomes of the most recent resolved branches. A lookup mixes low bits of the branch address with the history register to pick a counter. The lookup reports "taken" when that counter sits in its upper half. The mix is chosen at build time by a parameter. In one mode, address bits and history bits are placed side by side to form the index. In the other, address bits and history bits are combined bitwise with XOR.

A front end drives a branch address on the lookup port and reads the prediction in the same cycle. When the branch resolves, the back end presents the branch's address and its real direction with a valid strobe. On that clock edge the selected counter moves one step toward the outcome, and the outcome enters the history register. The width of each counter, the table index width and the history length are all parameters.

Top module: `ghist_dir_predictor`

## Requirements
- R1: A synchronous active-high reset sets every counter to the weakly-not-taken value 2^(CTR_W-1)-1 and clears the history to zero, so after reset every lookup returns not-taken.
- R2: The prediction is taken (1) exactly when the selected counter has its most significant bit set, that is, when its value is at least 2^(CTR_W-1).
- R3: On a valid resolution the selected counter increases by one for a taken outcome and decreases by one for a not-taken outcome. It stays at 2^CTR_W-1 and at 0 instead of wrapping.
- R4: On a valid resolution the history shifts one place toward its most significant bit, and the outcome (1 = taken) enters bit 0.
- R5: With HASH_MODE = HASH_CONCAT the index is {addr[IDX_W-HIST_LEN-1:0], hist[HIST_LEN-1:0]}. The address bits form the upper part and the history forms the lower part.
- R6: With HASH_MODE = HASH_XOR the index is addr[IDX_W-1:0] XOR the history, with the history zero-extended to IDX_W bits.
- R7: The lookup is combinational from the lookup address. A resolution that writes the same entry in the same cycle does not affect that cycle's lookup, and its effect shows from the next cycle on.
- R8: A resolution computes its index from its own address and from the history as it stood before that resolution's shift.
- R9: Address bits above those used by the selected hash have no effect on the index.
- R10: While the resolution valid input is low, no counter and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lookup_pc | input | PC_W | Address of the branch being predicted |
| lookup_taken | output | 1 | Predicted direction, 1 = taken |
| resolve_valid | input | 1 | A resolved branch is presented this cycle |
| resolve_pc | input | PC_W | Address of the resolved branch |
| resolve_taken | input | 1 | Real outcome of the resolved branch, 1 = taken |

## Verification
A wrong history bit corrupts the index at once, so the very next lookup can read the wrong counter. The error stays visible until the bad bit has been shifted out, which takes up to HIST_LEN resolutions. A wrong counter value, a wrap at either end, or an update written to the wrong entry stays hidden until a later lookup reaches that exact entry. That may happen many resolutions later, so the bench compares every cycle's prediction against a model of the whole table. It also drives long runs of the same outcome to push counters against both limits.

// File: rtl/gp_pkg.sv
package gp_pkg;

  // Index hash variants
  typedef enum logic {
    HASH_CONCAT = 1'b0,
    HASH_XOR    = 1'b1
  } hash_e;

endpackage

// File: rtl/gp_index_hash.sv
module gp_index_hash
  import gp_pkg::*;
#(
  parameter int    PC_W      = 32,
  parameter int    IDX_W     = 10,
  parameter int    HIST_LEN  = 6,
  parameter hash_e HASH_MODE = HASH_XOR
) (
  input  logic [PC_W-1:0]     pc,
  input  logic [HIST_LEN-1:0] hist,
  output logic [IDX_W-1:0]    idx
);

  generate
    if (HASH_MODE == HASH_CONCAT) begin : g_concat
      // Address bits on top, history bits below
      localparam int ADDR_BITS = IDX_W - HIST_LEN;
      logic unused_pc_hi;
      assign unused_pc_hi = ^pc[PC_W-1:ADDR_BITS];
      assign idx = {pc[ADDR_BITS-1:0], hist};
    end else begin : g_xor
      // History folded onto the low address bits
      logic unused_pc_hi;
      assign unused_pc_hi = ^pc[PC_W-1:IDX_W];
      assign idx = pc[IDX_W-1:0] ^ IDX_W'(hist);
    end
  endgenerate

endmodule

// File: rtl/gp_history.sv
module gp_history #(
  parameter int HIST_LEN = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic                shift_in,
  output logic [HIST_LEN-1:0] hist_q
);

  generate
    if (HIST_LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= shift_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_LEN-2:0], shift_in};
      end
    end
  endgenerate

endmodule

// File: rtl/gp_counter_table.sv
module gp_counter_table #(
  parameter int IDX_W = 10,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int             ENTRIES  = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_MIN  = '0;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_MAX >> 1;

  logic [CTR_W-1:0] ctr_mem [ENTRIES];
  logic [CTR_W-1:0] wr_cur;
  logic [CTR_W-1:0] wr_next;

  // Asynchronous read port for lookup and read-modify-write
  assign rd_ctr = ctr_mem[rd_idx];
  assign wr_cur = ctr_mem[wr_idx];

  // Saturating step toward the outcome
  always_comb begin
    wr_next = wr_cur;
    if (wr_taken) begin
      if (wr_cur != CTR_MAX) wr_next = wr_cur + 1'b1;
    end else begin
      if (wr_cur != CTR_MIN) wr_next = wr_cur - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) ctr_mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      ctr_mem[wr_idx] <= wr_next;
    end
  end

endmodule

// File: rtl/ghist_dir_predictor.sv
module ghist_dir_predictor
  import gp_pkg::*;
#(
  parameter int    PC_W      = 32,
  parameter int    IDX_W     = 10,
  parameter int    HIST_LEN  = 6,
  parameter int    CTR_W     = 2,
  parameter hash_e HASH_MODE = HASH_XOR
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lookup_pc,
  output logic            lookup_taken,
  input  logic            resolve_valid,
  input  logic [PC_W-1:0] resolve_pc,
  input  logic            resolve_taken
);

  logic [HIST_LEN-1:0] hist_q;
  logic [IDX_W-1:0]    lookup_idx;
  logic [IDX_W-1:0]    resolve_idx;
  logic [CTR_W-1:0]    lookup_ctr;

  // Both hashes see the history before any shift this cycle
  gp_index_hash #(
    .PC_W(PC_W), .IDX_W(IDX_W), .HIST_LEN(HIST_LEN), .HASH_MODE(HASH_MODE)
  ) u_lookup_hash (
    .pc  (lookup_pc),
    .hist(hist_q),
    .idx (lookup_idx)
  );

  gp_index_hash #(
    .PC_W(PC_W), .IDX_W(IDX_W), .HIST_LEN(HIST_LEN), .HASH_MODE(HASH_MODE)
  ) u_resolve_hash (
    .pc  (resolve_pc),
    .hist(hist_q),
    .idx (resolve_idx)
  );

  gp_history #(
    .HIST_LEN(HIST_LEN)
  ) u_history (
    .clk     (clk),
    .rst     (rst),
    .shift_en(resolve_valid),
    .shift_in(resolve_taken),
    .hist_q  (hist_q)
  );

  gp_counter_table #(
    .IDX_W(IDX_W), .CTR_W(CTR_W)
  ) u_table (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (lookup_idx),
    .rd_ctr  (lookup_ctr),
    .wr_en   (resolve_valid),
    .wr_idx  (resolve_idx),
    .wr_taken(resolve_taken)
  );

  assign lookup_taken = lookup_ctr[CTR_W-1];

endmodule

// File: rtl/gp_checker.sv
module gp_checker #(
  parameter int PC_W     = 32,
  parameter int HIST_LEN = 6
) (
  input logic                clk,
  input logic                rst,
  input logic [PC_W-1:0]     lookup_pc,
  input logic                lookup_taken,
  input logic                resolve_valid,
  input logic                resolve_taken,
  input logic [HIST_LEN-1:0] hist
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: history is clear on the first edge after reset is released
  always @(posedge clk) begin
    if (rst_d === 1'b1 && rst === 1'b0)
      assert_hist_cleared_R1: assert (hist == '0)
        else $error("history not cleared after reset");
  end

  // R4: newest outcome lands in bit 0
  assert_hist_newest_R4: assert property (@(posedge clk) disable iff (rst)
    resolve_valid |=> hist[0] == $past(resolve_taken));

  generate
    if (HIST_LEN > 1) begin : g_older
      // R4: older outcomes move one place up
      assert_hist_older_R4: assert property (@(posedge clk) disable iff (rst)
        resolve_valid |=> hist[HIST_LEN-1:1] == $past(hist[HIST_LEN-2:0]));
    end
  endgenerate

  // R10: no resolution, no history change
  assert_hist_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !resolve_valid |=> $stable(hist));

  // R7 / R10: without a resolution the same address keeps its prediction
  assert_lookup_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !resolve_valid |=> ($stable(lookup_pc) -> $stable(lookup_taken)));

endmodule

bind ghist_dir_predictor gp_checker #(
  .PC_W(PC_W), .HIST_LEN(HIST_LEN)
) u_gp_checker (
  .clk          (clk),
  .rst          (rst),
  .lookup_pc    (lookup_pc),
  .lookup_taken (lookup_taken),
  .resolve_valid(resolve_valid),
  .resolve_taken(resolve_taken),
  .hist         (hist_q)
);

// File: tb/ghist_dir_predictor_bench.sv
module ghist_dir_predictor_bench;
  import gp_pkg::*;

  localparam int PC_W     = 16;
  localparam int IDX_W    = 4;
  localparam int HIST_LEN = 2;
  localparam int CTR_W    = 3;
  localparam int ENTRIES  = 1 << IDX_W;
  localparam int CMAX     = (1 << CTR_W) - 1;
  localparam int CINIT    = (1 << (CTR_W - 1)) - 1;
  localparam int HALF     = 1 << (CTR_W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PC_W-1:0] lk_pc = '0;
  logic [PC_W-1:0] rs_pc = '0;
  logic rs_valid = 1'b0;
  logic rs_taken = 1'b0;
  logic pred_c, pred_x;

  always #10 clk = ~clk;  // 50 MHz

  ghist_dir_predictor #(
    .PC_W(PC_W), .IDX_W(IDX_W), .HIST_LEN(HIST_LEN), .CTR_W(CTR_W),
    .HASH_MODE(HASH_CONCAT)
  ) u_ghist_dir_predictor (
    .clk(clk), .rst(rst), .lookup_pc(lk_pc), .lookup_taken(pred_c),
    .resolve_valid(rs_valid), .resolve_pc(rs_pc), .resolve_taken(rs_taken)
  );

  ghist_dir_predictor #(
    .PC_W(PC_W), .IDX_W(IDX_W), .HIST_LEN(HIST_LEN), .CTR_W(CTR_W),
    .HASH_MODE(HASH_XOR)
  ) u_ghist_dir_predictor_xor (
    .clk(clk), .rst(rst), .lookup_pc(lk_pc), .lookup_taken(pred_x),
    .resolve_valid(rs_valid), .resolve_pc(rs_pc), .resolve_taken(rs_taken)
  );

  int tests = 0;
  int fails = 0;
  int m_c [ENTRIES];
  int m_x [ENTRIES];
  int m_hist;

  // Requirement-derived index forms for this configuration
  function automatic int idx_c(logic [PC_W-1:0] pc, int h);
    return (int'(pc[1:0]) << 2) | (h & 3);   // R5
  endfunction
  function automatic int idx_x(logic [PC_W-1:0] pc, int h);
    return int'(pc[3:0]) ^ (h & 3);          // R6
  endfunction

  function automatic int sat(int v, logic t);
    if (t) return (v < CMAX) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < ENTRIES; i++) begin
      m_c[i] = CINIT;
      m_x[i] = CINIT;
    end
    m_hist = 0;
  endtask

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare pre-update prediction, advance model
  task automatic step(input logic v, input logic [PC_W-1:0] upc, input logic t,
                      input logic [PC_W-1:0] qpc, input string tag);
    @(negedge clk);
    rs_valid = v; rs_pc = upc; rs_taken = t; lk_pc = qpc;
    #2;
    check({tag, " concat"}, pred_c, logic'(m_c[idx_c(qpc, m_hist)] >= HALF));
    check({tag, " xor"},    pred_x, logic'(m_x[idx_x(qpc, m_hist)] >= HALF));
    if (v) begin
      int ic, ix;
      ic = idx_c(upc, m_hist);
      ix = idx_x(upc, m_hist);
      m_c[ic] = sat(m_c[ic], t);
      m_x[ix] = sat(m_x[ix], t);
      m_hist  = ((m_hist << 1) | int'(t)) & 3;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rs_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  typedef struct packed {
    logic            v;
    logic [PC_W-1:0] upc;
    logic            t;
    logic [PC_W-1:0] qpc;
    logic            exp_c;
  } vec_t;

  // Hand-worked concat expectations (counter init 3, taken at >= 4)
  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0},
    '{1'b1, 16'h0001, 1'b1, 16'h0001, 1'b0},
    '{1'b0, 16'h0000, 1'b0, 16'h0001, 1'b0},
    '{1'b1, 16'h0001, 1'b0, 16'h0005, 1'b0},
    '{1'b1, 16'h0002, 1'b0, 16'h0002, 1'b0},
    '{1'b0, 16'h0000, 1'b0, 16'h0001, 1'b1},
    '{1'b0, 16'h0000, 1'b0, 16'hFFF5, 1'b1},
    '{1'b1, 16'h0003, 1'b1, 16'h0003, 1'b0},
    '{1'b1, 16'h0003, 1'b1, 16'h0001, 1'b0},
    '{1'b0, 16'h0000, 1'b0, 16'h0003, 1'b0},
    '{1'b1, 16'h0000, 1'b0, 16'h0000, 1'b0},
    '{1'b1, 16'h0000, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 16'h0000, 1'b0, 16'h0003, 1'b1},
    '{1'b0, 16'h0000, 1'b0, 16'h0001, 1'b1}
  };

  initial begin : watchdog
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    model_reset();
    do_reset();

    // R1: every entry reads not-taken after reset
    for (int a = 0; a < ENTRIES; a++) begin
      step(1'b0, '0, 1'b0, PC_W'(a), "R1 reset state");
      check("R1 reset concat fixed", pred_c, 1'b0);
      check("R1 reset xor fixed", pred_x, 1'b0);
    end

    // Vector table: R2 R5 R7 R8 R9 R10
    for (int n = 0; n < NVEC; n++) begin
      step(VECS[n].v, VECS[n].upc, VECS[n].t, VECS[n].qpc, "R2 R5 R6 R8 table model");
      check("R2 R5 R7 R8 R9 table concat", pred_c, VECS[n].exp_c);
    end

    // R3: drive to the top limit and back to the bottom limit
    for (int k = 0; k < 12; k++) step(1'b1, 16'h0000, 1'b1, 16'h0000, "R3 saturate high");
    for (int k = 0; k < 12; k++) step(1'b1, 16'h0000, 1'b0, 16'h0000, "R3 saturate low");
    for (int k = 0; k < 12; k++) step(1'b1, 16'h0004, 1'b1, 16'h0004, "R3 climb again");

    // R10: idle cycles with changing lookups
    for (int k = 0; k < 20; k++) step(1'b0, 16'h0001, 1'b1, PC_W'(k * 37), "R10 idle");

    // R4 R6 R9: mixed traffic
    for (int k = 0; k < 3000; k++) begin
      logic [PC_W-1:0] up, qp;
      logic v, t;
      up = PC_W'($urandom);
      qp = ((k % 3) == 0) ? up : PC_W'($urandom);
      v  = ($urandom % 4) != 0;
      t  = ($urandom % 3) != 0;
      step(v, up, t, qp, "R4 R6 R9 mixed");
    end

    // R1: reset again from a trained state
    do_reset();
    for (int a = 0; a < ENTRIES; a++) begin
      step(1'b0, '0, 1'b0, PC_W'(a * 4097), "R1 re-reset");
      check("R1 re-reset concat fixed", pred_c, 1'b0);
    end

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule